// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single memory-mapped timer channel with a 32-bit up-counter. Software starts, stops and clears the channel by writing to three command locations; the data written with a command is irrelevant, only the write itself matters. A terminal-count register sets the match point. A mode bit picks between a continuous run that reloads to zero after each match and a one-shot run that stops at the match. Each match raises a pending flag. The flag drives a level interrupt through a separate enable bit and is cleared by an acknowledge write.

The counter advances only in cycles where the `tick_en` input is high, so an external prescaler sets the rate. A continuous run with the terminal count at all ones gives a free-running, wrapping time base. Writes take effect on the clock edge that samples them. Reads are combinational from the address, so `rdata` reflects the addressed register in the same cycle.

The controller has two states, IDLE and ACTIVE. Its transitions are START (IDLE to ACTIVE on an enable command), STOP (ACTIVE to IDLE on a disable command), CLEAR (any state to IDLE on a reset command) and EXPIRE (ACTIVE to IDLE on a match in one-shot mode).

Top module: `tmr_channel`

## Requirements
- R1: Byte offsets are 0x00 clear command, 0x04 start command, 0x08 stop command, 0x0C mode, 0x10 status, 0x14 current count, 0x18 terminal count, 0x1C interrupt enable, 0x20 acknowledge. Reads of 0x00, 0x04, 0x08, 0x0C, 0x1C, 0x20 and of any unmapped offset return zero.
- R2: Any write to 0x04 moves the channel to ACTIVE and any write to 0x08 moves it to IDLE, whatever the write data.
- R3: The status word at 0x10 holds a run code in bits [3:0] (1 for IDLE, 2 for ACTIVE), bit 4 set while ACTIVE, bit 5 set for one-shot mode, bit 6 equal to the interrupt enable, and bit 7 equal to the pending flag. All higher bits are zero.
- R4: The count at 0x14 increases by one on each clock edge where `tick_en` is high and the channel is ACTIVE. It is unchanged otherwise, unless a clear command or a match acts on it.
- R5: In continuous mode (bit 0 of a write to 0x0C is 0), a counting edge at which the count equals the terminal count sets the pending flag and reloads the count to zero. The channel stays ACTIVE.
- R6: In one-shot mode (bit 0 written as 1), such a match sets the pending flag, leaves the count at the terminal count, and returns the channel to IDLE.
- R7: Any write to 0x00 clears the count and the pending flag and forces IDLE. The terminal count, mode and interrupt enable keep their values.
- R8: `irq` is high exactly when the pending flag and the interrupt enable (bit 0 of a write to 0x1C) are both set. The pending flag survives while the interrupt is disabled, so enabling the interrupt again raises `irq`.
- R9: A write to 0x20 with bit 7 set clears the pending flag. A write to 0x20 with bit 7 clear has no effect.
- R10: When an acknowledge and a new match fall on the same edge, the pending flag stays set.
- R11: The terminal count at 0x18 is read-write and holds all ones after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count-enable pulse from the external rate divider |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 8 | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is an acknowledge that lands on exactly the edge where the counter meets its terminal count. That case decides whether the clear or the new match wins. The bench first acknowledges, then counts up to the terminal value with pulsed ticks while idle cycles hold the count still. It then drives a tick and the acknowledge write in the same cycle, and checks that `irq` stays high and the count has reloaded. A second hard spot is the one-shot stop: after EXPIRE, further ticks must leave the held count untouched.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Byte offsets of the channel registers
    localparam int OFS_CLEAR  = 'h00;
    localparam int OFS_START  = 'h04;
    localparam int OFS_STOP   = 'h08;
    localparam int OFS_MODE   = 'h0C;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_COUNT  = 'h14;
    localparam int OFS_TERM   = 'h18;
    localparam int OFS_IE     = 'h1C;
    localparam int OFS_ACK    = 'h20;

    // Bit of the acknowledge write that clears the pending flag
    localparam int ACK_BIT    = 7;

    // Run codes reported in the status word
    localparam logic [3:0] RUN_CODE_IDLE   = 4'd1;
    localparam logic [3:0] RUN_CODE_ACTIVE = 4'd2;

    typedef enum logic [0:0] {
        TS_IDLE   = 1'b0,
        TS_ACTIVE = 1'b1
    } tmr_state_e;

    // One-hot decoded write commands
    typedef struct packed {
        logic clr;
        logic start;
        logic stop;
        logic mode_wr;
        logic term_wr;
        logic ie_wr;
        logic ack;
    } tmr_cmd_t;

endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output tmr_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
    localparam logic [ADDR_W-1:0] A_STOP  = ADDR_W'(OFS_STOP);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_TERM  = ADDR_W'(OFS_TERM);
    localparam logic [ADDR_W-1:0] A_IE    = ADDR_W'(OFS_IE);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

    always_comb begin
        cmd         = '0;
        cmd.clr     = wr_en && (addr == A_CLEAR);
        cmd.start   = wr_en && (addr == A_START);
        cmd.stop    = wr_en && (addr == A_STOP);
        cmd.mode_wr = wr_en && (addr == A_MODE);
        cmd.term_wr = wr_en && (addr == A_TERM);
        cmd.ie_wr   = wr_en && (addr == A_IE);
        cmd.ack     = wr_en && (addr == A_ACK);
    end

endmodule

// File: rtl/tmr_cfg.sv
module tmr_cfg
    import tmr_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] TC_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_cmd_t          cmd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] term_q,
    output logic              mode_os,
    output logic              ie_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            term_q <= TC_RESET;
        end else if (cmd.term_wr) begin
            term_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_os <= 1'b0;
        end else if (cmd.mode_wr) begin
            mode_os <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (cmd.ie_wr) begin
            ie_q <= wdata[0];
        end
    end

endmodule

// File: rtl/tmr_fsm_ctr.sv
module tmr_fsm_ctr
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_cmd_t          cmd,
    input  logic              tick_en,
    input  logic              mode_os,
    input  logic [DATA_W-1:0] term_q,
    output tmr_state_e        state_q,
    output logic [DATA_W-1:0] count_q,
    output logic              hit,
    output logic              active,
    output logic [3:0]        run_code
);

    tmr_state_e        state_d;
    logic              step;
    logic              at_term;
    logic [DATA_W-1:0] count_d;

    // A counting edge: running, ticked, and not overridden by a command
    assign step    = (state_q == TS_ACTIVE) && tick_en && !cmd.stop && !cmd.clr;
    assign at_term = (count_q == term_q);
    assign hit     = step && at_term;

    // Next-state logic: START, STOP, CLEAR, EXPIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_IDLE: begin
                if (cmd.start) begin
                    state_d = TS_ACTIVE;          // START
                end
            end
            TS_ACTIVE: begin
                if (cmd.clr || cmd.stop) begin
                    state_d = TS_IDLE;            // CLEAR or STOP
                end else if (hit && mode_os) begin
                    state_d = TS_IDLE;            // EXPIRE
                end
            end
            default: state_d = TS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Count next value
    always_comb begin
        count_d = count_q;
        if (cmd.clr) begin
            count_d = '0;
        end else if (step) begin
            if (at_term) begin
                count_d = mode_os ? count_q : '0;
            end else begin
                count_d = count_q + DATA_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            TS_ACTIVE: begin
                active   = 1'b1;
                run_code = RUN_CODE_ACTIVE;
            end
            default: begin
                active   = 1'b0;
                run_code = RUN_CODE_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/tmr_pend.sv
module tmr_pend
    import tmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tmr_cmd_t cmd,
    input  logic     ack_bit,
    input  logic     hit,
    output logic     pend_q
);

    // Priority: clear command, then a new match, then acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (cmd.clr) begin
            pend_q <= 1'b0;
        end else if (hit) begin
            pend_q <= 1'b1;
        end else if (cmd.ack && ack_bit) begin
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] TC_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int STAT_USED = 8;
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_TERM   = ADDR_W'(OFS_TERM);

    tmr_cmd_t          cmd;
    tmr_state_e        state_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] tc_q;
    logic              mode_os;
    logic              ie_q;
    logic              pend_q;
    logic              hit;
    logic              active;
    logic [3:0]        run_code;
    logic [DATA_W-1:0] status_w;

    tmr_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .cmd   (cmd)
    );

    tmr_cfg #(.DATA_W(DATA_W), .TC_RESET(TC_RESET)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .wdata   (wdata),
        .term_q  (tc_q),
        .mode_os (mode_os),
        .ie_q    (ie_q)
    );

    tmr_fsm_ctr #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .tick_en  (tick_en),
        .mode_os  (mode_os),
        .term_q   (tc_q),
        .state_q  (state_q),
        .count_q  (count_q),
        .hit      (hit),
        .active   (active),
        .run_code (run_code)
    );

    tmr_pend u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .ack_bit (wdata[ACK_BIT]),
        .hit     (hit),
        .pend_q  (pend_q)
    );

    assign status_w = {{(DATA_W-STAT_USED){1'b0}}, pend_q, ie_q, mode_os, active, run_code};

    always_comb begin
        unique case (addr)
            A_STATUS: rdata = status_w;
            A_COUNT:  rdata = count_q;
            A_TERM:   rdata = tc_q;
            default:  rdata = '0;
        endcase
    end

    assign irq = pend_q && ie_q;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input tmr_state_e        state_q,
    input logic [DATA_W-1:0] count_q,
    input logic [DATA_W-1:0] tc_q,
    input logic              mode_os,
    input logic              pend_q
);

    logic w_clr, w_start, w_stop, w_ack1, at_hit;

    assign w_clr   = wr_en && (addr == ADDR_W'(OFS_CLEAR));
    assign w_start = wr_en && (addr == ADDR_W'(OFS_START));
    assign w_stop  = wr_en && (addr == ADDR_W'(OFS_STOP));
    assign w_ack1  = wr_en && (addr == ADDR_W'(OFS_ACK)) && wdata[ACK_BIT];
    assign at_hit  = (state_q == TS_ACTIVE) && tick_en && !w_stop && !w_clr
                     && (count_q == tc_q);

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        w_start |=> state_q == TS_ACTIVE);

    a_r2_stop: assert property (@(posedge clk) disable iff (!rst_n)
        w_stop |=> state_q == TS_IDLE);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en || state_q == TS_IDLE) && !w_clr |=> $stable(count_q));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_ACTIVE) && tick_en && !w_stop && !w_clr && (count_q != tc_q)
        |=> count_q == DATA_W'($past(count_q) + DATA_W'(1)));

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        at_hit && !mode_os |=> (count_q == '0) && pend_q && (state_q == TS_ACTIVE));

    a_r6_expire: assert property (@(posedge clk) disable iff (!rst_n)
        at_hit && mode_os |=> (state_q == TS_IDLE) && pend_q && $stable(count_q));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        w_clr |=> (count_q == '0) && !pend_q && (state_q == TS_IDLE) && $stable(tc_q));

    a_r8_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> pend_q);

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        w_ack1 && !at_hit |=> !pend_q);

    a_r10_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        w_ack1 && at_hit |=> pend_q);

endmodule

bind tmr_channel tmr_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq     (irq),
    .state_q (state_q),
    .count_q (count_q),
    .tc_q    (tc_q),
    .mode_os (mode_os),
    .pend_q  (pend_q)
);

// File: tb/tmr_channel_test.sv
module tmr_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Scoreboard queues (one entry per expected item)
    string       q_tag[$];
    bit          q_isirq[$];
    logic [31:0] q_exp[$];

    always #5 clk = ~clk;

    tmr_channel uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq)
    );

    // Monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_tag.size() > 0) begin
                string       t;
                bit          isirq;
                logic [31:0] e;
                logic [31:0] act;
                t     = q_tag.pop_front();
                isirq = q_isirq.pop_front();
                e     = q_exp.pop_front();
                act   = isirq ? {31'b0, irq} : rdata;
                checks++;
                if (act !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, act, e);
                end
            end
        end
    end

    // Driver tasks: each starts and ends at a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'h0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        addr = a;
        q_tag.push_back(t); q_isirq.push_back(1'b0); q_exp.push_back(e);
        #4;
        @(negedge clk);
    endtask

    task automatic expect_irq(input logic e, input string t);
        q_tag.push_back(t); q_isirq.push_back(1'b1); q_exp.push_back({31'b0, e});
        #4;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R3, R11, R4, R8)
        expect_rd(8'h10, 32'h01, "R3 status after reset");
        expect_rd(8'h14, 32'h0, "R4 count after reset");
        expect_rd(8'h18, 32'hFFFF_FFFF, "R11 terminal count after reset");
        expect_irq(1'b0, "R8 irq after reset");

        // Configuration (R11, R1, R3)
        wr(8'h18, 32'd3);
        expect_rd(8'h18, 32'd3, "R11 terminal count readback");
        wr(8'h1C, 32'd1);
        wr(8'h0C, 32'hFFFF_FFFE);
        expect_rd(8'h0C, 32'h0, "R1 mode reads zero");
        expect_rd(8'h1C, 32'h0, "R1 irq enable reads zero");
        expect_rd(8'h10, 32'h41, "R3 status idle ie continuous");

        // Start with arbitrary data (R2), counting (R4)
        wr(8'h04, 32'hDEAD_BEEF);
        expect_rd(8'h10, 32'h52, "R2 start with junk data");
        expect_rd(8'h14, 32'd0, "R4 no tick no count");
        ticks(2);
        expect_rd(8'h14, 32'd2, "R4 two ticks");
        repeat (3) @(negedge clk);
        expect_rd(8'h14, 32'd2, "R4 holds without tick");

        // Continuous match (R5, R8)
        ticks(1);
        expect_rd(8'h14, 32'd3, "R4 count reaches terminal");
        ticks(1);
        expect_rd(8'h14, 32'd0, "R5 reload to zero");
        expect_rd(8'h10, 32'hD2, "R5 pending and still active");
        expect_irq(1'b1, "R8 irq on match");

        // Acknowledge (R9)
        wr(8'h20, 32'h7F);
        expect_irq(1'b1, "R9 ack without bit 7 ignored");
        wr(8'h20, 32'h80);
        expect_irq(1'b0, "R9 ack clears");
        expect_rd(8'h10, 32'h52, "R9 status pending cleared");

        // Pending survives while interrupt disabled (R8)
        wr(8'h1C, 32'd0);
        ticks(4);
        expect_irq(1'b0, "R8 irq masked");
        expect_rd(8'h10, 32'h92, "R8 pending held while masked");
        wr(8'h1C, 32'd1);
        expect_irq(1'b1, "R8 irq on re-enable");

        // Ack on the same edge as a new match (R10)
        wr(8'h20, 32'h80);
        expect_irq(1'b0, "R10 pre-clear");
        ticks(3);
        expect_rd(8'h14, 32'd3, "R10 count at terminal");
        tick_en = 1'b1; wr_en = 1'b1; addr = 8'h20; wdata = 32'h80;
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0; wdata = 32'h0;
        expect_irq(1'b1, "R10 match wins over ack");
        expect_rd(8'h14, 32'd0, "R10 count reloaded");

        // Stop with arbitrary data (R2, R4)
        wr(8'h08, 32'h0001_2345);
        expect_rd(8'h10, 32'hC1, "R2 stop with junk data");
        ticks(2);
        expect_rd(8'h14, 32'd0, "R4 idle ignores ticks");

        // Clear command (R7)
        wr(8'h04, 32'h0);
        ticks(2);
        expect_rd(8'h14, 32'd2, "R7 count before clear");
        wr(8'h00, 32'hFFFF_FFFF);
        expect_rd(8'h14, 32'd0, "R7 count cleared");
        expect_rd(8'h10, 32'h41, "R7 idle, pending cleared, ie kept");
        expect_rd(8'h18, 32'd3, "R7 terminal count kept");
        expect_irq(1'b0, "R7 irq low after clear");

        // One-shot (R6)
        wr(8'h0C, 32'd1);
        expect_rd(8'h10, 32'h61, "R6 one-shot mode shown");
        wr(8'h04, 32'h0);
        expect_rd(8'h10, 32'h72, "R6 one-shot active");
        ticks(4);
        expect_rd(8'h14, 32'd3, "R6 count held at terminal");
        expect_rd(8'h10, 32'hE1, "R6 idle with pending");
        expect_irq(1'b1, "R6 irq after expire");
        ticks(2);
        expect_rd(8'h14, 32'd3, "R6 no counting after expire");

        // Write-only and unmapped offsets read zero (R1)
        expect_rd(8'h00, 32'h0, "R1 clear offset reads zero");
        expect_rd(8'h04, 32'h0, "R1 start offset reads zero");
        expect_rd(8'h08, 32'h0, "R1 stop offset reads zero");
        expect_rd(8'h20, 32'h0, "R1 ack offset reads zero");
        expect_rd(8'h40, 32'h0, "R1 unmapped offset reads zero");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule